// File: doc/BRIEF.md
# Serial Boot Chip-Erase Responder

This block sequences the byte exchange of the chip-erase command in a serial boot loader. A UART-style receiver hands it one byte per `rx_valid` pulse together with a receive-error flag. The first byte taken is the operation command, which is echoed back. A fixed-length body follows: several password bytes and then a checksum byte. The block answers that body with one acknowledge code. It then takes an erase-enable byte and acknowledges it as well. When the enable byte is accepted, it raises a request to the flash controller. It reports the erase outcome with a final end code and then waits for the next command.

The password comparison is done elsewhere and arrives as the `pw_ok` level. A `pw_required` level selects whether the body is checked at all. All acknowledge bytes leave through a single-entry valid/ready transmit port. While an acknowledge is waiting or an erase is running, the block takes no receive bytes, and any byte offered in that time is dropped.

Top module: `bx_erase_responder`

## Requirements
- R1: After a synchronous active-low reset, or when `rst_n` is driven low in the middle of a sequence, `tx_valid` and `erase_req` are low and the next accepted byte is treated as an operation command.
- R2: The operation command byte is echoed unchanged as an acknowledge. Its upper nibble is kept for use later in the sequence.
- R3: With `pw_required` low, the acknowledge to the body (BODY_LEN bytes, 13 by default) is 0x40 whatever the receive errors, the checksum and `pw_ok` are.
- R4: With `pw_required` high, a receive error on any body byte gives 0x48. This outranks the checksum and password checks.
- R5: With `pw_required` high and no receive errors, the block adds all body bytes, the checksum byte included. If the low 8 bits of that sum are not zero, the acknowledge is 0x41 whatever `pw_ok` is.
- R6: With `pw_required` high, no errors and a good checksum, the acknowledge is 0x41 when `pw_ok` is low and 0x40 when it is high. `pw_ok` is sampled as the last body byte is taken.
- R7: After any failing acknowledge (0x41, 0x48, 0x58, 0xN1), the next accepted byte is treated as a new operation command.
- R8: An erase-enable byte that arrives with its receive error set is answered with 0x58, even if its value is 0x54.
- R9: A clean enable byte equal to 0x54 is echoed as 0x54. `erase_req` rises in the cycle after that acknowledge is taken.
- R10: A clean enable byte that is not 0x54 is answered with the upper nibble of the last command byte above a low nibble of 0x1.
- R11: `erase_req` stays high until `erase_done`. Then the end code is 0x4F, or 0x4C if `erase_err` is high in the `erase_done` cycle, and the block returns to waiting for a command.
- R12: Once `tx_valid` is high, it stays high with `tx_data` unchanged until a cycle in which `tx_ready` is high.
- R13: Bytes offered while an acknowledge is pending or an erase is in progress are discarded and do not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: received byte present |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive error flag for the byte |
| pw_required | input | 1 | Password checking enabled |
| pw_ok | input | 1 | External password comparison passed |
| tx_valid | output | 1 | Acknowledge byte waiting |
| tx_data | output | 8 | Acknowledge byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| erase_req | output | 1 | Chip-erase request to flash controller |
| erase_done | input | 1 | Erase finished (one-cycle pulse) |
| erase_err | input | 1 | Erase failed, valid with erase_done |

## Verification
The assertions assume three things about the inputs. `erase_done` arrives only while `erase_req` is high. Each `rx_valid` pulse lasts a single cycle. `tx_ready` may be held off for any number of cycles. The bench pulses `erase_done` only after it has seen `erase_req` high, and gives `rx_valid` exactly one cycle per byte. It stalls `tx_ready` for random spans so that R12 is exercised, and it injects stray bytes during pending acknowledges and during erases. Random bodies set a valid checksum about half the time, so every branch of the acknowledge priority is reached.

// File: rtl/bx_erase_pkg.sv
// Package: shared codes and state encoding for the chip-erase responder.
// Assumes 8-bit serial bytes.
package bx_erase_pkg;
    localparam logic [7:0] ACK_OK       = 8'h40;
    localparam logic [7:0] ACK_BAD      = 8'h41;
    localparam logic [7:0] ACK_COMM     = 8'h48;
    localparam logic [7:0] EN_CODE      = 8'h54;
    localparam logic [7:0] EN_COMM      = 8'h58;
    localparam logic [3:0] EN_REJ_LO    = 4'h1;
    localparam logic [7:0] END_OK       = 8'h4F;
    localparam logic [7:0] END_FAIL     = 8'h4C;

    typedef enum logic [2:0] {
        ST_CMD,    // waiting for an operation command
        ST_BODY,   // collecting password and checksum bytes
        ST_EN,     // waiting for the erase-enable byte
        ST_ACK,    // acknowledge pending on the transmit port
        ST_ERASE   // erase request outstanding
    } seq_state_t;
endpackage

// File: rtl/bx_body_check.sv
// Module: bx_body_check
// Counts the body bytes and keeps a running 8-bit sum and a sticky receive
// error over them. It shows the totals including the byte being taken, so the
// sequencer can decide in the cycle the last byte arrives.
// Assumes take is high for exactly one cycle per accepted body byte and that
// clr comes with each accepted command byte.
module bx_body_check #(
    parameter int BODY_LEN = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       take,
    input  logic [7:0] byte_in,
    input  logic       err_in,
    output logic       last,
    output logic [7:0] sum_total,
    output logic       err_total
);
    localparam int CNT_W = (BODY_LEN > 1) ? $clog2(BODY_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BODY_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       sum_q;
    logic             err_q;

    // Combined totals including the byte currently presented.
    always_comb begin
        sum_total = sum_q + byte_in;
        err_total = err_q | err_in;
        last      = take && (cnt_q == LAST_IDX);
    end

    // Byte counter, running sum and sticky error over one body.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            sum_q <= '0;
            err_q <= 1'b0;
        end else if (take) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
            sum_q <= sum_total;
            err_q <= err_total;
        end
    end

    // The counter never passes the last body index (R4/R5 framing).
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);
endmodule

// File: rtl/bx_ack_tx.sv
// Module: bx_ack_tx
// Single-entry holding register for acknowledge bytes with valid/ready output.
// Assumes load is issued only while the register is empty.
module bx_ack_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       sent
);
    assign sent = tx_valid && tx_ready;

    // Hold the byte until the transmitter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_data;
        end else if (sent) begin
            tx_valid <= 1'b0;
        end
    end

    // A waiting byte is held unchanged until tx_ready.
    assert_hold_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // No new byte is loaded over one still waiting.
    assert_no_overwrite_R13: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !tx_valid);
endmodule

// File: rtl/bx_seq.sv
// Module: bx_seq
// Protocol sequencer: command echo, body verdict, enable check, erase
// request and end code. Every acknowledge passes through ST_ACK, which
// returns to a stored state once the byte is taken.
// Assumes erase_done pulses only while erase_req is high.
module bx_seq
    import bx_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_err,
    input  logic       pw_required,
    input  logic       pw_ok,
    input  logic       body_last,
    input  logic [7:0] body_sum,
    input  logic       body_err,
    input  logic       ack_sent,
    input  logic       erase_done,
    input  logic       erase_err,
    output logic       body_clr,
    output logic       body_take,
    output logic       ack_load,
    output logic [7:0] ack_data,
    output logic       erase_req
);
    seq_state_t state_q, state_d, ret_q, ret_d;
    logic [3:0] cmd_hi_q;
    logic       take;

    assign take      = rx_valid && (state_q == ST_CMD || state_q == ST_BODY || state_q == ST_EN);
    assign body_clr  = rx_valid && (state_q == ST_CMD);
    assign body_take = rx_valid && (state_q == ST_BODY);
    assign erase_req = (state_q == ST_ERASE);

    // Next-state and acknowledge selection.
    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        ack_load = 1'b0;
        ack_data = 8'h00;
        case (state_q)
            ST_CMD: if (take) begin
                ack_load = 1'b1;
                ack_data = rx_data;
                ret_d    = ST_BODY;
                state_d  = ST_ACK;
            end
            ST_BODY: if (body_last) begin
                ack_load = 1'b1;
                state_d  = ST_ACK;
                if (!pw_required)        ack_data = ACK_OK;
                else if (body_err)       ack_data = ACK_COMM;
                else if (body_sum != 0)  ack_data = ACK_BAD;
                else if (!pw_ok)         ack_data = ACK_BAD;
                else                     ack_data = ACK_OK;
                ret_d = (ack_data == ACK_OK) ? ST_EN : ST_CMD;
            end
            ST_EN: if (take) begin
                ack_load = 1'b1;
                state_d  = ST_ACK;
                if (rx_err) begin
                    ack_data = EN_COMM;
                    ret_d    = ST_CMD;
                end else if (rx_data == EN_CODE) begin
                    ack_data = EN_CODE;
                    ret_d    = ST_ERASE;
                end else begin
                    ack_data = {cmd_hi_q, EN_REJ_LO};
                    ret_d    = ST_CMD;
                end
            end
            ST_ACK: if (ack_sent) state_d = ret_q;
            ST_ERASE: if (erase_done) begin
                ack_load = 1'b1;
                ack_data = erase_err ? END_FAIL : END_OK;
                ret_d    = ST_CMD;
                state_d  = ST_ACK;
            end
            default: state_d = ST_CMD;
        endcase
    end

    // State, return state and command nibble registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CMD;
            ret_q    <= ST_CMD;
            cmd_hi_q <= '0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            if (body_clr) cmd_hi_q <= rx_data[7:4];
        end
    end

    // The request stays up until the controller reports completion.
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> erase_req);

    // Completion arrives only while a request is outstanding.
    assert_done_in_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> erase_req);

    // No acknowledge is loaded while an erase is in progress except its end code.
    assert_ack_only_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_load && erase_req) |-> erase_done);
endmodule

// File: rtl/bx_erase_responder.sv
// Module: bx_erase_responder (top)
// Chip-erase responder for a serial boot loader. It joins the body checker,
// the sequencer and the acknowledge holding register.
// Assumes single-cycle rx_valid pulses and single-cycle erase_done pulses.
module bx_erase_responder #(
    parameter int BODY_LEN = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_err,
    input  logic       pw_required,
    input  logic       pw_ok,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       erase_req,
    input  logic       erase_done,
    input  logic       erase_err
);
    logic       body_clr, body_take, body_last, body_err;
    logic [7:0] body_sum;
    logic       ack_load, ack_sent;
    logic [7:0] ack_data;

    bx_body_check #(.BODY_LEN(BODY_LEN)) u_body (
        .clk(clk), .rst_n(rst_n), .clr(body_clr), .take(body_take),
        .byte_in(rx_data), .err_in(rx_err), .last(body_last),
        .sum_total(body_sum), .err_total(body_err)
    );

    bx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .pw_required(pw_required), .pw_ok(pw_ok),
        .body_last(body_last), .body_sum(body_sum), .body_err(body_err),
        .ack_sent(ack_sent), .erase_done(erase_done), .erase_err(erase_err),
        .body_clr(body_clr), .body_take(body_take), .ack_load(ack_load),
        .ack_data(ack_data), .erase_req(erase_req)
    );

    bx_ack_tx u_tx (
        .clk(clk), .rst_n(rst_n), .load(ack_load), .load_data(ack_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .sent(ack_sent)
    );

    // The erase request starts only after the 0x54 echo has been taken (R9).
    assert_req_after_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req) |-> (!tx_valid && tx_data == 8'h54));

    // Request and a waiting acknowledge never overlap.
    assert_req_tx_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_req && tx_valid));
endmodule

// File: tb/sim_bx_erase_responder.sv
module sim_bx_erase_responder;
    localparam int N = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_data = '0;
    logic       pw_required = 1'b0, pw_ok = 1'b0;
    logic       tx_valid, erase_req;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0, erase_done = 1'b0, erase_err = 1'b0;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    bx_erase_responder #(.BODY_LEN(N)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .pw_required(pw_required), .pw_ok(pw_ok),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .erase_req(erase_req), .erase_done(erase_done), .erase_err(erase_err)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input logic e);
        rx_valid = 1'b1; rx_data = d; rx_err = e;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0; rx_err = 1'b0;
    endtask

    // Expect an acknowledge now; optionally stall, inject a stray byte, then take it.
    task automatic expect_ack(input logic [7:0] exp, input int stall, input bit junk, input string tag);
        check({7'd0, tx_valid}, 8'd1, {tag, " valid"});
        check(tx_data, exp, tag);
        if (junk) send_byte(8'h54, 1'b0); // R13: stray byte ignored
        for (int i = 0; i < stall; i++) @(negedge clk);
        if (stall > 0) check(tx_data, exp, "R12 held");
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    endtask

    function automatic logic [7:0] body_code(bit req, bit anyerr, logic [7:0] s, bit ok);
        if (!req) return 8'h40;
        if (anyerr) return 8'h48;
        if (s != 0) return 8'h41;
        return ok ? 8'h40 : 8'h41;
    endfunction

    task automatic session(input logic [7:0] cmd, input logic [7:0] seed_b, input bit fix_sum,
                           input logic [N-1:0] errs, input bit req, input bit ok,
                           input logic [7:0] en, input bit en_e, input bit er_e, input string tag);
        logic [7:0] body [N];
        logic [7:0] s, code, ecode;
        int stall;
        s = '0;
        for (int i = 0; i < N; i++) begin
            body[i] = seed_b + 8'(i * 37);
            if (i == N - 1 && fix_sum) body[i] = 8'(-s);
            s = s + body[i];
        end
        pw_required = req; pw_ok = ok;
        send_byte(cmd, 1'b0);
        expect_ack(cmd, $urandom % 3, 1'b0, "R2 cmd echo");
        for (int i = 0; i < N; i++) send_byte(body[i], errs[i]);
        code = body_code(req, |errs, s, ok);
        expect_ack(code, $urandom % 3, $urandom % 2, {tag, " body ack"});
        if (code != 8'h40) return;
        send_byte(en, en_e);
        if (en_e) ecode = 8'h58;
        else if (en == 8'h54) ecode = 8'h54;
        else ecode = {cmd[7:4], 4'h1};
        expect_ack(ecode, $urandom % 2, 1'b0, "R8/R9/R10 enable ack");
        if (ecode != 8'h54) return;
        check({7'd0, erase_req}, 8'd1, "R9 erase_req rises");
        stall = 1 + $urandom % 4;
        send_byte(8'h33, 1'b0); // R13 stray during erase
        for (int i = 0; i < stall; i++) @(negedge clk);
        check({7'd0, erase_req}, 8'd1, "R11 erase_req held");
        erase_done = 1'b1; erase_err = er_e;
        @(negedge clk); erase_done = 1'b0; erase_err = 1'b0;
        check({7'd0, erase_req}, 8'd0, "R11 erase_req drops");
        expect_ack(er_e ? 8'h4C : 8'h4F, 0, 1'b0, "R11 end code");
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check({6'd0, tx_valid, erase_req}, 8'd0, "R1 reset state");
        rst_n = 1'b1; @(negedge clk);
        // Directed corners
        session(8'hA0, 8'h11, 0, 13'h0105, 0, 0, 8'h54, 0, 0, "R3 pw off");
        session(8'hA0, 8'h22, 0, 13'h1000, 1, 0, 8'h54, 0, 0, "R4 rx err");
        session(8'hA0, 8'h23, 0, 13'h0000, 1, 0, 8'h54, 0, 0, "R5 bad sum");
        session(8'hA0, 8'h24, 1, 13'h0000, 1, 0, 8'h54, 0, 0, "R6 pw fail");
        session(8'hA0, 8'h25, 1, 13'h0000, 1, 1, 8'h54, 1, 0, "R8 R7");
        session(8'hA0, 8'h26, 1, 13'h0000, 1, 1, 8'h55, 0, 0, "R10");
        session(8'h7C, 8'h27, 1, 13'h0000, 1, 1, 8'h54, 0, 1, "R11 fail");
        session(8'hA0, 8'h28, 1, 13'h0000, 1, 1, 8'h54, 0, 0, "R6 R9 pass");
        // Reset in mid-body
        send_byte(8'h5A, 1'b0);
        expect_ack(8'h5A, 0, 1'b0, "R2 cmd echo");
        send_byte(8'h01, 1'b0); send_byte(8'h02, 1'b0);
        rst_n = 1'b0; @(negedge clk);
        check({6'd0, tx_valid, erase_req}, 8'd0, "R1 mid reset");
        rst_n = 1'b1; @(negedge clk);
        session(8'hB3, 8'h40, 1, 13'h0000, 1, 1, 8'h54, 0, 0, "R1 after reset");
        // Random sessions
        for (int k = 0; k < 60; k++) begin
            logic [N-1:0] em;
            em = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) : '0;
            session(8'($urandom), 8'($urandom), $urandom % 2, em, ($urandom % 4) != 0,
                    ($urandom % 3) != 0, (($urandom % 3) == 0) ? 8'($urandom) : 8'h54,
                    ($urandom % 5) == 0, $urandom % 2, "R3-6 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule